// File: doc/BRIEF.md
# Cartridge Mapper Bus Interface

This block sits on the processor side of a cartridge mapper. It watches byte writes on a 16-bit address bus and sorts them by the top three address bits. From those writes it keeps a mode byte, a 7-bit ROM bank number and an SRAM bank number. A fourth region is the external-RAM data window.

Depending on the mode, the window behaves in one of three ways. It can be plain SRAM, either read-only or writable. It can be a command/response port built around an 8-bit value register. When the window is unmapped it returns open-bus 0xFF.

In commit mode, a window write does not store data. It raises a one-cycle strobe for an external command processor. That processor can also load a response into the value register. The SRAM array and the ROM live outside this block.

Top module: `mapper_bus_if`

## Requirements
- R1: After reset the mode byte is 0x00, the ROM bank is 1, the SRAM bank is 0, the commit strobe is low and the value register is 0x00.
- R2: Writes are decoded by busAddr[15:13]. Region 1 sets romBank to busWrData[6:0]. Region 2 sets sramBank to busWrData. Regions 3, 4, 6 and 7 change no output.
- R3: A region 0 write stores the whole byte as the mode. The mode codes are 0x00 (SRAM read-only), 0x0A (SRAM read-write), 0x0B (input), 0x0C (output) and 0x0D (commit). Any other byte, for example 0x1A, counts as an unmapped mode.
- R4: busRdData equals sramRdData in modes 0x00 and 0x0A. It equals 0x80 OR the value register in modes 0x0B and 0x0C. It is 0xFF in every other mode.
- R5: A region 5 write in mode 0x0B loads the value register with 0x80 OR busWrData. The new value is visible on cmdValue in the next cycle.
- R6: A region 5 write in mode 0x0D raises cmdStrobe for exactly one cycle, in the cycle after the write edge. It leaves the value register unchanged.
- R7: sramWe is high, in the same cycle, only for a region 5 write while the mode is 0x0A. It stays low for every write in mode 0x00.
- R8: Region 5 writes in modes other than 0x0A, 0x0B and 0x0D are ignored. The value register, cmdStrobe and sramWe all stay unchanged.
- R9: rspLoad loads rspValue into the value register at the next edge. If an input-mode window write arrives in the same cycle, the bus write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe for the processor bus |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Bus write byte |
| busRdData | output | 8 | Byte returned for a data-window read |
| sramRdData | input | 8 | Byte read from the external SRAM |
| sramWe | output | 1 | Write enable for the external SRAM |
| romBank | output | 7 | Selected ROM bank |
| sramBank | output | 8 | Selected SRAM bank |
| cmdStrobe | output | 1 | One-cycle commit pulse to the command processor |
| cmdValue | output | 8 | Current value register |
| rspLoad | input | 1 | Command processor loads the value register |
| rspValue | input | 8 | Response byte from the command processor |

## Verification
Timing differs by output:
- sramWe and busRdData are combinational. The bench samples them while the write is still held, or right after a mode change has settled.
- The mode, the banks and the value register change at the write edge. The bench samples them on the following falling edge.
- cmdStrobe is registered. It is checked high on the falling edge after the write edge and low one cycle later.

Because inputs are driven on falling edges and outputs are read half a cycle later, no result depends on process ordering at the active edge.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam logic [7:0] MODE_SRAM_RO = 8'h00;
  localparam logic [7:0] MODE_SRAM_RW = 8'h0A;
  localparam logic [7:0] MODE_IN      = 8'h0B;
  localparam logic [7:0] MODE_OUT     = 8'h0C;
  localparam logic [7:0] MODE_COMMIT  = 8'h0D;

  localparam logic [2:0] REG_MODE   = 3'd0;
  localparam logic [2:0] REG_ROM    = 3'd1;
  localparam logic [2:0] REG_RAM    = 3'd2;
  localparam logic [2:0] REG_WINDOW = 3'd5;

  typedef struct packed {
    logic modeWr;
    logic romWr;
    logic ramWr;
    logic valueWr;
    logic sramWe;
    logic commit;
  } ctrlStrobes_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        modeQ,
  output ctrlStrobes_t      strobes,
  output logic              cmdStrobe
);
  localparam int REGION_LSB = ADDR_W - 3;

  logic [2:0] region;
  logic       winWr;

  assign region = busAddr[ADDR_W-1:REGION_LSB];
  assign winWr  = busWr && (region == REG_WINDOW);

  always_comb begin
    strobes         = '0;
    strobes.modeWr  = busWr && (region == REG_MODE);
    strobes.romWr   = busWr && (region == REG_ROM);
    strobes.ramWr   = busWr && (region == REG_RAM);
    strobes.valueWr = winWr && (modeQ == MODE_IN);
    strobes.sramWe  = winWr && (modeQ == MODE_SRAM_RW);
    strobes.commit  = winWr && (modeQ == MODE_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmdStrobe <= 1'b0;
    else       cmdStrobe <= strobes.commit;
  end
endmodule

// File: rtl/mapper_dp.sv
module mapper_dp
  import mapper_pkg::*;
#(
  parameter int ROM_W = 7,
  parameter int RAM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [7:0]       busWrData,
  input  logic [7:0]       sramRdData,
  input  logic             rspLoad,
  input  logic [7:0]       rspValue,
  output logic [7:0]       modeQ,
  output logic [ROM_W-1:0] romBank,
  output logic [RAM_W-1:0] sramBank,
  output logic [7:0]       valueQ,
  output logic [7:0]       rdData
);
  localparam logic [ROM_W-1:0] ROM_RESET = ROM_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ    <= MODE_SRAM_RO;
      romBank  <= ROM_RESET;
      sramBank <= '0;
      valueQ   <= '0;
    end else begin
      if (strobes.modeWr) modeQ    <= busWrData;
      if (strobes.romWr)  romBank  <= busWrData[ROM_W-1:0];
      if (strobes.ramWr)  sramBank <= RAM_W'(busWrData);
      if (strobes.valueWr)  valueQ <= 8'h80 | busWrData;
      else if (rspLoad)     valueQ <= rspValue;
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_SRAM_RO, MODE_SRAM_RW: rdData = sramRdData;
      MODE_IN, MODE_OUT:          rdData = 8'h80 | valueQ;
      default:                    rdData = 8'hFF;
    endcase
  end
endmodule

// File: rtl/mapper_bus_if.sv
module mapper_bus_if
  import mapper_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROM_W  = 7,
  parameter int RAM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [7:0]        sramRdData,
  output logic              sramWe,
  output logic [ROM_W-1:0]  romBank,
  output logic [RAM_W-1:0]  sramBank,
  output logic              cmdStrobe,
  output logic [7:0]        cmdValue,
  input  logic              rspLoad,
  input  logic [7:0]        rspValue
);
  ctrlStrobes_t strobes;
  logic [7:0]   modeQ;

  mapper_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .modeQ(modeQ), .strobes(strobes), .cmdStrobe(cmdStrobe)
  );

  mapper_dp #(.ROM_W(ROM_W), .RAM_W(RAM_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .sramRdData(sramRdData), .rspLoad(rspLoad), .rspValue(rspValue),
    .modeQ(modeQ), .romBank(romBank), .sramBank(sramBank),
    .valueQ(cmdValue), .rdData(busRdData)
  );

  assign sramWe = strobes.sramWe;
endmodule

// File: rtl/mapper_bus_if_chk.sv
module mapper_bus_if_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWr,
  input logic [15:0] busAddr,
  input logic [7:0]  busWrData,
  input logic [7:0]  busRdData,
  input logic        sramWe,
  input logic [6:0]  romBank,
  input logic        cmdStrobe,
  input logic [7:0]  cmdValue,
  input logic [7:0]  modeQ
);
  // R7
  sram_we_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    sramWe |-> (busWr && modeQ == 8'h0A && busAddr[15:13] == 3'd5));

  // R6
  commit_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[15:13] == 3'd5 && modeQ == 8'h0D) |=> cmdStrobe);

  // R6
  commit_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(busWr && modeQ == 8'h0D));

  // R2
  rom_bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[15:13] == 3'd1) |=> romBank == $past(busWrData[6:0]));

  // R4
  port_read_msb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 8'h0B || modeQ == 8'h0C) |-> busRdData[7]);

  // R5
  input_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[15:13] == 3'd5 && modeQ == 8'h0B) |=> cmdValue == ($past(busWrData) | 8'h80));
endmodule

bind mapper_bus_if mapper_bus_if_chk uChk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .sramWe(sramWe),
  .romBank(romBank), .cmdStrobe(cmdStrobe), .cmdValue(cmdValue),
  .modeQ(modeQ)
);

// File: tb/tb_mapper_bus_if.sv
`timescale 1ns/1ps
module tb_mapper_bus_if;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [7:0]  sramRdData = 8'h5C;
  logic        sramWe;
  logic [6:0]  romBank;
  logic [7:0]  sramBank;
  logic        cmdStrobe;
  logic [7:0]  cmdValue;
  logic        rspLoad = 1'b0;
  logic [7:0]  rspValue = '0;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mapper_bus_if dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .sramRdData(sramRdData),
    .sramWe(sramWe), .romBank(romBank), .sramBank(sramBank),
    .cmdStrobe(cmdStrobe), .cmdValue(cmdValue), .rspLoad(rspLoad),
    .rspValue(rspValue)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one write starting on a falling edge.
  // Returns on the falling edge after the write edge.
  // weSeen holds sramWe as sampled during the write cycle.
  task automatic busWrite(input logic [2:0] region, input logic [7:0] data, output logic weSeen);
    busAddr   = {region, 13'h0123};
    busWrData = data;
    busWr     = 1'b1;
    #1 weSeen = sramWe;
    @(posedge clk);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic setMode(input logic [7:0] m);
    logic we;
    busWrite(3'd0, m, we);
  endtask

  task automatic testReset();
    check("R1 rom", romBank, 7'd1);
    check("R1 ram", sramBank, 8'd0);
    check("R1 strobe", cmdStrobe, 1'b0);
    check("R1 value", cmdValue, 8'h00);
    check("R1 mode ro read", busRdData, 8'h5C);
  endtask

  task automatic testBanks();
    logic we;
    busWrite(3'd1, 8'hFF, we);
    check("R2 rom low7", romBank, 7'h7F);
    busWrite(3'd1, 8'h85, we);
    check("R2 rom", romBank, 7'h05);
    busWrite(3'd2, 8'hA7, we);
    check("R2 ram", sramBank, 8'hA7);
    busWrite(3'd3, 8'h11, we);
    busWrite(3'd4, 8'h22, we);
    busWrite(3'd6, 8'h33, we);
    busWrite(3'd7, 8'h44, we);
    check("R2 other rom", romBank, 7'h05);
    check("R2 other ram", sramBank, 8'hA7);
    check("R2 other mode", busRdData, 8'h5C);
  endtask

  task automatic testSram();
    logic we;
    busWrite(3'd5, 8'h12, we);
    check("R7 ro no we", we, 1'b0);
    setMode(8'h0A);
    check("R4 rw read", busRdData, 8'h5C);
    busWrite(3'd5, 8'h12, we);
    check("R7 rw we", we, 1'b1);
    busWrite(3'd2, 8'h01, we);
    check("R7 rw non-window", we, 1'b0);
  endtask

  task automatic testInput();
    logic we;
    setMode(8'h0B);
    busWrite(3'd5, 8'h03, we);
    check("R5 value", cmdValue, 8'h83);
    check("R5 no we", we, 1'b0);
    check("R4 in read", busRdData, 8'h83);
    setMode(8'h0C);
    check("R4 out read", busRdData, 8'h83);
  endtask

  task automatic testCommit();
    logic we;
    setMode(8'h0D);
    check("R4 commit read", busRdData, 8'hFF);
    busWrite(3'd5, 8'h61, we);
    check("R6 strobe high", cmdStrobe, 1'b1);
    check("R6 value kept", cmdValue, 8'h83);
    check("R6 no we", we, 1'b0);
    @(negedge clk);
    check("R6 strobe one cycle", cmdStrobe, 1'b0);
  endtask

  task automatic testIgnored();
    logic we;
    setMode(8'h0C);
    busWrite(3'd5, 8'h44, we);
    check("R8 out value", cmdValue, 8'h83);
    check("R8 out strobe", cmdStrobe, 1'b0);
    check("R8 out we", we, 1'b0);
    setMode(8'h1A);
    check("R3 full byte read", busRdData, 8'hFF);
    busWrite(3'd5, 8'h44, we);
    check("R3 full byte no we", we, 1'b0);
    check("R8 unmapped value", cmdValue, 8'h83);
  endtask

  task automatic testResponse();
    logic we;
    setMode(8'h0B);
    rspValue = 8'h27;
    rspLoad  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rspLoad = 1'b0;
    check("R9 load", cmdValue, 8'h27);
    check("R9 read", busRdData, 8'hA7);
    rspValue = 8'h01;
    rspLoad  = 1'b1;
    busWrite(3'd5, 8'h09, we);
    rspLoad = 1'b0;
    check("R9 bus wins", cmdValue, 8'h89);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBanks();
    testSram();
    testInput();
    testCommit();
    testIgnored();
    testResponse();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule